// File: doc/BRIEF.md
# Shared Receive Packet FIFO with Inline Status

This block is the single receive buffer that every host channel shares, for periodic and non-periodic traffic alike. The link side offers a packet in two steps. First it presents a descriptor: channel, byte count, data PID and a validity code. It then streams the packet's payload words. The block packs the descriptor into a status word and stores it ahead of the payload in the same storage. Successive packets sit back to back with no gaps. Storage always begins at word address 0, and only the depth can be changed, through a parameter.

Before it accepts a descriptor, the block checks that there is room for the status word and for every payload word of the packet. A packet that does not fit is dropped whole: its payload words are swallowed and a one-cycle overflow pulse is raised. An accepted packet becomes visible to the reader only once its last word is stored.

The reader sees a show-ahead head word. It pops the status word first, then exactly as many payload words as the byte count implies. A flag tells the reader when the head word is a status word.

Top module: `rx_pkt_fifo`

## Requirements
- R1: After reset the FIFO is empty: `rd_valid_o`, `rd_sts_avail_o` and `lnk_ovf_o` are all 0.
- R2: The status word carries the channel in bits 3:0, the byte count in bits 14:4, the PID in bits 16:15 and the validity code in bits 20:17. Bits 31:21 are zero.
- R3: A packet is accepted only if 1 + ceil(bytes/4) words are free. Otherwise `lnk_ovf_o` is 1 for exactly the cycle after the descriptor strobe, the packet's payload words are discarded, and the stored contents do not change.
- R4: An accepted packet stores ceil(bytes/4) payload words after its status word. Byte 0 is in bits 7:0. In the last word, the bytes beyond the byte count read as zero.
- R5: Packets from any mix of channels are read out in arrival order, each status word followed directly by its payload.
- R6: A packet with a byte count of 0 stores only a status word. The word that follows it is the next packet's status word.
- R7: A packet is invisible to the reader until its last word is written. `rd_valid_o` rises in the cycle after the last word is accepted, or after the status word when the byte count is 0.
- R8: `rd_sts_avail_o` is 1 exactly when `rd_valid_o` is 1 and the head word is a status word.
- R9: A pop while `rd_valid_o` is 0 is ignored.
- R10: A packet that exactly fills the free space is accepted. Space released by pops is reused as the address wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lnk_sts_vld_i | input | 1 | Descriptor strobe that starts a packet |
| lnk_ch_i | input | 4 | Destination channel |
| lnk_bcnt_i | input | 11 | Payload byte count |
| lnk_pid_i | input | 2 | Data PID |
| lnk_code_i | input | 4 | Validity code |
| lnk_dat_vld_i | input | 1 | Payload word strobe |
| lnk_dat_i | input | 32 | Payload word, byte 0 in bits 7:0 |
| lnk_ovf_o | output | 1 | One-cycle pulse when a packet is dropped |
| rd_pop_i | input | 1 | Pop the head word |
| rd_data_o | output | 32 | Head word, show-ahead |
| rd_valid_o | output | 1 | A committed word is at the head |
| rd_sts_avail_o | output | 1 | The head word is a status word |

## Verification
The overflow pulse is registered, so it is due one cycle after the descriptor strobe. The bench samples it on the falling edge that follows that rising edge. Commit is also registered, so `rd_valid_o` is checked as low on the falling edge after the status word is taken and as high on the falling edge after the last payload word. The head word and the status flag are combinational from the read pointer, so the bench compares them on each falling edge before it raises the pop. Each pop takes effect on the next rising edge.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CH_W   = 4;
  localparam int unsigned BC_W   = 11;
  localparam int unsigned PID_W  = 2;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned NW_W   = BC_W - 1;
  localparam int unsigned BC_LSB = CH_W;
  localparam int unsigned RSV_W  = WORD_W - CH_W - BC_W - PID_W - CODE_W;

  typedef struct packed {
    logic [RSV_W-1:0]  rsvd;
    logic [CODE_W-1:0] code;
    logic [PID_W-1:0]  pid;
    logic [BC_W-1:0]   bcnt;
    logic [CH_W-1:0]   ch;
  } rx_sts_t;

  function automatic logic [NW_W-1:0] words_of(input logic [BC_W-1:0] bc);
    return NW_W'(((BC_W+1)'({1'b0, bc}) + (BC_W+1)'(3)) >> 2);
  endfunction

  function automatic logic [WORD_W-1:0] keep_mask(input logic [1:0] lb);
    case (lb)
      2'd1:    return 32'h0000_00FF;
      2'd2:    return 32'h0000_FFFF;
      2'd3:    return 32'h00FF_FFFF;
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/rx_ram.sv
module rx_ram #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rx_wr_ctrl.sv
module rx_wr_ctrl
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sts_vld_i,
  input  rx_sts_t           sts_i,
  input  logic              dat_vld_i,
  input  logic [WORD_W-1:0] dat_i,
  input  logic [PW-1:0]     rd_ptr_i,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic [PW-1:0]     commit_ptr_o,
  output logic              ovf_o
);
  typedef enum logic [1:0] {S_IDLE, S_RECV, S_DROP} wr_state_e;

  wr_state_e       state_q;
  logic [PW-1:0]   wp_q, cwp_q;
  logic [NW_W-1:0] rem_q, nw;
  logic [1:0]      lb_q;
  logic [PW-1:0]   occ;
  logic            fits;

  always_comb begin
    occ     = wp_q - rd_ptr_i;
    nw      = words_of(sts_i.bcnt);
    // status word plus all payload words must fit
    fits    = (32'(nw) + 32'd1) <= (32'(DEPTH) - 32'(occ));
    we_o    = 1'b0;
    waddr_o = wp_q[AW-1:0];
    wdata_o = '0;
    case (state_q)
      S_IDLE: if (sts_vld_i && fits) begin
        we_o    = 1'b1;
        wdata_o = sts_i;
      end
      S_RECV: if (dat_vld_i) begin
        we_o    = 1'b1;
        wdata_o = (rem_q == NW_W'(1)) ? (dat_i & keep_mask(lb_q)) : dat_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      wp_q    <= '0;
      cwp_q   <= '0;
      rem_q   <= '0;
      lb_q    <= '0;
      ovf_o   <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      if (we_o) wp_q <= wp_q + PW'(1);
      case (state_q)
        S_IDLE: if (sts_vld_i) begin
          if (fits) begin
            if (nw == '0) cwp_q <= wp_q + PW'(1);
            else begin
              state_q <= S_RECV;
              rem_q   <= nw;
              lb_q    <= sts_i.bcnt[1:0];
            end
          end else begin
            ovf_o <= 1'b1;
            if (nw != '0) begin
              state_q <= S_DROP;
              rem_q   <= nw;
            end
          end
        end
        S_RECV: if (dat_vld_i) begin
          rem_q <= rem_q - NW_W'(1);
          if (rem_q == NW_W'(1)) begin
            cwp_q   <= wp_q + PW'(1);
            state_q <= S_IDLE;
          end
        end
        S_DROP: if (dat_vld_i) begin
          rem_q <= rem_q - NW_W'(1);
          if (rem_q == NW_W'(1)) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign commit_ptr_o = cwp_q;

  assert_no_overrun_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (32'(occ) < 32'(DEPTH)));
  assert_drop_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_vld_i && state_q == S_IDLE && !fits) |=> ovf_o);
  assert_drop_no_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DROP) |-> !we_o);
  assert_last_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && state_q == S_RECV && rem_q == NW_W'(1) && lb_q == 2'd1) |-> (wdata_o[31:8] == '0));
  assert_commit_behind_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(PW'(wp_q - cwp_q)) <= 32'(DEPTH));
endmodule

// File: rtl/rx_rd_parse.sv
module rx_rd_parse
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pop_i,
  input  logic [PW-1:0]   commit_ptr_i,
  input  logic [BC_W-1:0] head_bcnt_i,
  output logic [PW-1:0]   rd_ptr_o,
  output logic [AW-1:0]   raddr_o,
  output logic            valid_o,
  output logic            sts_avail_o
);
  logic [PW-1:0]   rp_q;
  logic [NW_W-1:0] rem_q;  // payload words left in the packet at the head

  assign valid_o     = (commit_ptr_i != rp_q);
  assign sts_avail_o = valid_o && (rem_q == '0);
  assign rd_ptr_o    = rp_q;
  assign raddr_o     = rp_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q  <= '0;
      rem_q <= '0;
    end else if (pop_i && valid_o) begin
      rp_q <= rp_q + PW'(1);
      if (rem_q == '0) rem_q <= words_of(head_bcnt_i);
      else             rem_q <= rem_q - NW_W'(1);
    end
  end

  assert_empty_pop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !valid_o) |=> $stable(rp_q));
  assert_zlp_next_sts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && sts_avail_o && head_bcnt_i == '0) |=> (rem_q == '0));
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        lnk_sts_vld_i,
  input  logic [3:0]  lnk_ch_i,
  input  logic [10:0] lnk_bcnt_i,
  input  logic [1:0]  lnk_pid_i,
  input  logic [3:0]  lnk_code_i,
  input  logic        lnk_dat_vld_i,
  input  logic [31:0] lnk_dat_i,
  output logic        lnk_ovf_o,
  input  logic        rd_pop_i,
  output logic [31:0] rd_data_o,
  output logic        rd_valid_o,
  output logic        rd_sts_avail_o
);
  rx_sts_t           sts;
  logic              we;
  logic [AW-1:0]     waddr, raddr;
  logic [WORD_W-1:0] wdata;
  logic [PW-1:0]     cwp, rp;

  always_comb begin
    sts      = '0;
    sts.ch   = lnk_ch_i;
    sts.bcnt = lnk_bcnt_i;
    sts.pid  = lnk_pid_i;
    sts.code = lnk_code_i;
  end

  rx_wr_ctrl #(.DEPTH(DEPTH)) i_wr (
    .clk_i, .rst_ni,
    .sts_vld_i(lnk_sts_vld_i), .sts_i(sts),
    .dat_vld_i(lnk_dat_vld_i), .dat_i(lnk_dat_i),
    .rd_ptr_i(rp),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
    .commit_ptr_o(cwp), .ovf_o(lnk_ovf_o)
  );

  rx_ram #(.DEPTH(DEPTH), .W(WORD_W)) i_ram (
    .clk_i, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rd_data_o)
  );

  rx_rd_parse #(.DEPTH(DEPTH)) i_rd (
    .clk_i, .rst_ni,
    .pop_i(rd_pop_i), .commit_ptr_i(cwp),
    .head_bcnt_i(rd_data_o[BC_LSB +: BC_W]),
    .rd_ptr_o(rp), .raddr_o(raddr),
    .valid_o(rd_valid_o), .sts_avail_o(rd_sts_avail_o)
  );

  assert_occ_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(PW'(cwp - rp)) <= 32'(DEPTH));
  assert_sts_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sts_avail_o |-> rd_valid_o);
endmodule

// File: tb/test_rx_pkt_fifo.sv
module test_rx_pkt_fifo;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sts_vld = 1'b0, dat_vld = 1'b0, pop = 1'b0;
  logic [3:0]  ch = '0, code = '0;
  logic [10:0] bcnt = '0;
  logic [1:0]  pid = '0;
  logic [31:0] dat = '0;
  logic        ovf, rvalid, savail;
  logic [31:0] rdata;

  int checks = 0, errors = 0;
  logic [31:0] exp_w[$];
  bit          exp_s[$];
  int          model_occ = 0;

  always #5 clk = ~clk; // 100 MHz

  rx_pkt_fifo #(.DEPTH(DEPTH)) i_rx_pkt_fifo (
    .clk_i(clk), .rst_ni(rst_n),
    .lnk_sts_vld_i(sts_vld), .lnk_ch_i(ch), .lnk_bcnt_i(bcnt),
    .lnk_pid_i(pid), .lnk_code_i(code),
    .lnk_dat_vld_i(dat_vld), .lnk_dat_i(dat), .lnk_ovf_o(ovf),
    .rd_pop_i(pop), .rd_data_o(rdata), .rd_valid_o(rvalid), .rd_sts_avail_o(savail)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nwords(input int bc);
    return (bc + 3) / 4;
  endfunction

  // visible: rd_valid is expected low until the packet commits
  task automatic send_pkt(input int c, input int bc, input int p, input int cd,
                          input int seed, input bit visible);
    int nw;
    bit fits;
    logic [31:0] w, m;
    nw   = nwords(bc);
    fits = (model_occ + 1 + nw) <= DEPTH;
    @(negedge clk);
    sts_vld = 1'b1; ch = 4'(c); bcnt = 11'(bc); pid = 2'(p); code = 4'(cd);
    if (fits) begin
      exp_w.push_back({11'b0, 4'(cd), 2'(p), 11'(bc), 4'(c)}); // R2 layout
      exp_s.push_back(1'b1);
      model_occ += 1 + nw;
    end
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      sts_vld = 1'b0;
      if (i == 0) begin
        chk("R3 ovf", 32'(ovf), 32'(!fits));
        if (visible && fits) chk("R7 hidden", 32'(rvalid), 32'd0);
      end
      w = 32'h1122_3344 + 32'(seed) * 32'h0101_0101 + 32'(i);
      dat_vld = 1'b1; dat = w;
      if (fits) begin
        m = '1;
        if (i == nw - 1 && (bc % 4) != 0) m = (32'd1 << (8 * (bc % 4))) - 1;
        exp_w.push_back(w & m);
        exp_s.push_back(1'b0);
      end
    end
    @(negedge clk);
    sts_vld = 1'b0; dat_vld = 1'b0;
    if (nw == 0) chk("R3 ovf", 32'(ovf), 32'(!fits));
    if (visible && fits) chk("R7 commit", 32'(rvalid), 32'd1);
  endtask

  task automatic drain();
    while (exp_w.size() > 0) begin
      logic [31:0] e;
      bit s;
      e = exp_w.pop_front();
      s = exp_s.pop_front();
      @(negedge clk);
      chk("R5 valid", 32'(rvalid), 32'd1);
      chk("R8 sts flag", 32'(savail), 32'(s));
      chk(s ? "R2 status word" : "R4 payload word", rdata, e);
      pop = 1'b1;
      model_occ--;
    end
    @(negedge clk);
    pop = 1'b0;
    chk("R5 empty after drain", 32'(rvalid), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 valid", 32'(rvalid), 32'd0);
    chk("R1 sts", 32'(savail), 32'd0);
    chk("R1 ovf", 32'(ovf), 32'd0);
  endtask

  task automatic t_basic();
    send_pkt(3, 8, 2, 2, 1, 1'b1);
    drain();
    send_pkt(15, 2047 % 64, 3, 15, 2, 1'b1); // R2 all-ones ch/code
    drain();
  endtask

  task automatic t_partial();  // R4 masking for each remainder
    send_pkt(1, 5, 0, 1, 3, 1'b1);
    send_pkt(2, 6, 1, 1, 4, 1'b0);
    send_pkt(4, 7, 2, 1, 5, 1'b0);
    send_pkt(5, 1, 3, 1, 6, 1'b0);
    drain();
  endtask

  task automatic t_zlp();  // R6
    send_pkt(6, 0, 1, 3, 7, 1'b1);
    send_pkt(7, 4, 0, 2, 8, 1'b0);
    send_pkt(8, 0, 2, 3, 9, 1'b0);
    drain();
  endtask

  task automatic t_multi_ch();  // R5
    for (int k = 0; k < 4; k++) send_pkt(k * 3, 3 + k * 5, k, 2, 10 + k, 1'b0);
    drain();
  endtask

  task automatic t_overflow();  // R3, R10
    send_pkt(9, 120, 0, 2, 20, 1'b1);  // 31 words
    send_pkt(10, 4, 1, 2, 21, 1'b0);   // needs 2, 1 free: dropped
    send_pkt(11, 0, 2, 2, 22, 1'b0);   // exactly fills: R10
    send_pkt(12, 0, 3, 2, 23, 1'b0);   // full: dropped
    drain();
  endtask

  task automatic t_empty_pop();  // R9
    @(negedge clk);
    pop = 1'b1;
    repeat (3) @(negedge clk);
    pop = 1'b0;
    chk("R9 still empty", 32'(rvalid), 32'd0);
    send_pkt(13, 3, 1, 2, 30, 1'b1);
    @(negedge clk);
    chk("R9 head is status", 32'(savail), 32'd1);
    drain();
  endtask

  task automatic t_wrap();  // R10 reuse across wrap
    for (int r = 0; r < 6; r++) begin
      send_pkt(r, r * 13 + 9, r % 4, 2, 40 + r, 1'b1);
      send_pkt(r + 1, 40, 1, 2, 50 + r, 1'b0);
      drain();
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_partial();
    t_zlp();
    t_multi_ch();
    t_overflow();
    t_empty_pop();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule